// File: doc/BRIEF.md
# Three-State Power Mode Controller

This block sets the power mode of a small system chip. It has three visible modes. In Operating, the CPU clock, the peripheral clocks and the main oscillator all run. In Idle, only the CPU clock stops, and the peripherals and oscillator keep running. In Standby, the oscillator and every clock stop. Software asks for Idle or Standby with a one-cycle write strobe and a mode code. A key-press line or an interrupt line brings the block back.

Four supply-supervision inputs are sampled together with the two wake lines:
- battery good;
- external supply present (active low);
- power fail (active low);
- battery changed (active low).

A power failure forces the block into Standby. While any supply fault is present, a wake from Standby is refused. Leaving Standby first turns the oscillator on. The block then waits for a programmable settle count before the clocks start again.

Inside, the state machine has four states: RUN (Operating), IDLE, SLEEP (Standby) and SETTLE (oscillator starting). The transitions are:
- RUN→IDLE on a software Idle request;
- RUN→SLEEP on a software Standby request or a power fail;
- IDLE→RUN on a wake;
- IDLE→SLEEP on a power fail;
- SLEEP→SETTLE on an accepted wake;
- SETTLE→RUN when the settle count runs out.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in Operating with all three enables high, and status reads 3'b000.
- R2: Enables by state: Operating gives cpu=1, periph=1, osc=1; Idle gives 0,1,1; Standby gives 0,0,0; settling gives 0,0,1. status[1:0] is 0 for Operating, 1 for Idle and 2 for Standby (settling also reads 2). The code 3 never appears.
- R3: A write strobe in Operating with req_mode 1 enters Idle at the next clock edge. With req_mode 2 it enters Standby and clears the cause bit. Codes 0 and 3, and any strobe outside Operating, change nothing.
- R4: A wake (key or interrupt) seen in Idle returns the block to Operating at the next edge, with no settle delay.
- R5: An accepted wake in Standby enters settling with the value of settle_val at that edge. The block stays in settling for settle_val+1 cycles and then enters Operating.
- R6: A wake in Standby is ignored while any of these faults holds: battery good is low and external power is absent (ext_pwr_n=1); pwr_fail_n is low; bat_chg_n is low.
- R7: A power fail seen in Operating or Idle forces Standby at the next edge and sets status[2]=1. It takes priority over a software request and over a wake in the same cycle.
- R8: status[2] records the cause of the last Standby entry (1 = power fail, 0 = software). It keeps its value until the next Standby entry.
- R9: Wake events in Operating or during settling have no effect.
- R10: The wake and supervision inputs pass a two-flop synchronizer. A change first sampled at one rising edge acts on the state at the second rising edge after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_we | input | 1 | Software mode request strobe |
| req_mode | input | 2 | Requested mode: 1 Idle, 2 Standby |
| wake_key | input | 1 | Key-press wake (asynchronous) |
| wake_irq | input | 1 | Interrupt wake (asynchronous) |
| settle_val | input | SETTLE_W | Oscillator settle count |
| bat_ok | input | 1 | Battery good, active high |
| ext_pwr_n | input | 1 | External supply present, active low |
| pwr_fail_n | input | 1 | Power fail, active low |
| bat_chg_n | input | 1 | Battery changed, active low |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| status | output | 3 | {cause, state code} |

## Verification
Software requests are applied with every mode code, in and out of Operating. This shows that only codes 1 and 2 act, and only from Operating. Wake pulses are sent on each line in each state. This separates the direct return from Idle from the counted return from Standby, and shows that wakes are dead in Operating and in settling. Standby wakes are repeated under each fault combination and then with the fault cleared, which proves the refusal is tied to the fault and not to the wake. Power fails arrive together with a request and in Idle, and settle counts of 0 and 5 are used, which probes priority, the cause bit and the off-by-one edges of the settle window.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_IDLE   = 2'd1,
        PM_SLEEP  = 2'd2,
        PM_SETTLE = 2'd3
    } pm_state_e;

    localparam logic [1:0] REQ_IDLE = 2'd1;
    localparam logic [1:0] REQ_STBY = 2'd2;

    // synchronized input vector bit positions
    localparam int SI_BATOK = 0;
    localparam int SI_EXTN  = 1;
    localparam int SI_PFN   = 2;
    localparam int SI_CHGN  = 3;
    localparam int SI_KEY   = 4;
    localparam int SI_IRQ   = 5;
    localparam int SI_W     = 6;
    localparam logic [SI_W-1:0] SI_RST = 6'b00_1111;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int W = 6,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pmc_supv.sv
module pmc_supv
    import pmc_pkg::*;
(
    input  logic [SI_W-1:0] si,
    output logic            wake,
    output logic            pfail,
    output logic            blocked
);
    logic no_supply;

    assign wake      = si[SI_KEY] | si[SI_IRQ];
    assign pfail     = ~si[SI_PFN];
    assign no_supply = ~si[SI_BATOK] & si[SI_EXTN];
    assign blocked   = no_supply | pfail | ~si[SI_CHGN];
endmodule

// File: rtl/pmc_settle.sv
module pmc_settle #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int SETTLE_W    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_we,
    input  logic [1:0]          req_mode,
    input  logic                wake_key,
    input  logic                wake_irq,
    input  logic [SETTLE_W-1:0] settle_val,
    input  logic                bat_ok,
    input  logic                ext_pwr_n,
    input  logic                pwr_fail_n,
    input  logic                bat_chg_n,
    output logic                cpu_clk_en,
    output logic                periph_clk_en,
    output logic                osc_en,
    output logic [2:0]          status
);
    logic [SI_W-1:0] si_raw, si_s;
    logic            wake_s, pfail_s, blocked_s;
    logic            settle_load, settle_done;
    pm_state_e       state_q, state_d;
    logic            cause_q, cause_d;

    assign si_raw = {wake_irq, wake_key, bat_chg_n, pwr_fail_n, ext_pwr_n, bat_ok};

    pmc_sync #(.W(SI_W), .STAGES(SYNC_STAGES), .RST_VAL(SI_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (si_raw),
        .q     (si_s)
    );

    pmc_supv u_supv (
        .si      (si_s),
        .wake    (wake_s),
        .pfail   (pfail_s),
        .blocked (blocked_s)
    );

    pmc_settle #(.CW(SETTLE_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (settle_load),
        .load_val (settle_val),
        .done     (settle_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PM_RUN;
            cause_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    // transitions
    always_comb begin
        state_d     = state_q;
        cause_d     = cause_q;
        settle_load = 1'b0;
        unique case (state_q)
            PM_RUN: begin
                if (pfail_s) begin
                    state_d = PM_SLEEP;
                    cause_d = 1'b1;
                end else if (req_we && req_mode == REQ_IDLE) begin
                    state_d = PM_IDLE;
                end else if (req_we && req_mode == REQ_STBY) begin
                    state_d = PM_SLEEP;
                    cause_d = 1'b0;
                end
            end
            PM_IDLE: begin
                if (pfail_s) begin
                    state_d = PM_SLEEP;
                    cause_d = 1'b1;
                end else if (wake_s) begin
                    state_d = PM_RUN;
                end
            end
            PM_SLEEP: begin
                if (wake_s && !blocked_s) begin
                    state_d     = PM_SETTLE;
                    settle_load = 1'b1;
                end
            end
            PM_SETTLE: begin
                if (settle_done) state_d = PM_RUN;
            end
        endcase
    end

    // outputs
    always_comb begin
        cpu_clk_en    = 1'b0;
        periph_clk_en = 1'b0;
        osc_en        = 1'b0;
        status        = {cause_q, 2'd2};
        unique case (state_q)
            PM_RUN: begin
                cpu_clk_en    = 1'b1;
                periph_clk_en = 1'b1;
                osc_en        = 1'b1;
                status        = {cause_q, 2'd0};
            end
            PM_IDLE: begin
                periph_clk_en = 1'b1;
                osc_en        = 1'b1;
                status        = {cause_q, 2'd1};
            end
            PM_SLEEP: begin
                status        = {cause_q, 2'd2};
            end
            PM_SETTLE: begin
                osc_en        = 1'b1;
                status        = {cause_q, 2'd2};
            end
        endcase
    end
endmodule

// File: rtl/pmc_chk.sv
module pmc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_clk_en,
    input logic       periph_clk_en,
    input logic       osc_en,
    input logic [2:0] status,
    input logic       wake_s,
    input logic       pfail_s,
    input logic       blocked_s
);
    // R2
    cpu_needs_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> (periph_clk_en && osc_en));

    // R2
    periph_needs_osc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_clk_en |-> osc_en);

    // R2
    state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[1:0] != 2'd3);

    // R5
    settle_clocks_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_en && !periph_clk_en) |-> (!cpu_clk_en && status[1:0] == 2'd2));

    // R7
    pfail_forces_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] != 2'd2 && pfail_s) |=> (status[1:0] == 2'd2 && status[2] && !osc_en));

    // R4
    idle_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] == 2'd1 && wake_s && !pfail_s) |=> (status[1:0] == 2'd0));

    // R6
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] == 2'd2 && !osc_en && blocked_s) |=> (status[1:0] == 2'd2 && !osc_en));

    // R8
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1:0] == 2'd2 && $past(status[1:0]) == 2'd2) |-> $stable(status[2]));
endmodule

bind pwr_mode_ctrl pmc_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .osc_en        (osc_en),
    .status        (status),
    .wake_s        (wake_s),
    .pfail_s       (pfail_s),
    .blocked_s     (blocked_s)
);

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_we = 1'b0;
    logic [1:0]    req_mode = 2'd0;
    logic          wake_key = 1'b0;
    logic          wake_irq = 1'b0;
    logic [SW-1:0] settle_val = '0;
    logic          bat_ok = 1'b1;
    logic          ext_pwr_n = 1'b1;
    logic          pwr_fail_n = 1'b1;
    logic          bat_chg_n = 1'b1;
    logic          cpu_clk_en, periph_clk_en, osc_en;
    logic [2:0]    status;

    int    checks = 0;
    int    errors = 0;
    string phase  = "R1";
    bit    armed  = 1'b0;

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.SETTLE_W(SW)) dut (
        .clk(clk), .rst_n(rst_n), .req_we(req_we), .req_mode(req_mode),
        .wake_key(wake_key), .wake_irq(wake_irq), .settle_val(settle_val),
        .bat_ok(bat_ok), .ext_pwr_n(ext_pwr_n), .pwr_fail_n(pwr_fail_n),
        .bat_chg_n(bat_chg_n), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .osc_en(osc_en), .status(status)
    );

    // behavioural reference: 0 run, 1 idle, 2 standby, 3 settling
    int       m_st = 0;
    int       m_cnt = 0;
    bit       m_cause = 1'b0;
    bit [5:0] d1 = 6'b001111, d2 = 6'b001111;
    bit       m_wake, m_pf, m_blk;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_cause = 0;
            d1 = 6'b001111; d2 = 6'b001111;
            armed = 1'b1;
        end else begin
            m_wake = d2[4] | d2[5];
            m_pf   = !d2[2];
            m_blk  = (!d2[0] && d2[1]) || !d2[2] || !d2[3];
            case (m_st)
                0: if (m_pf) begin m_st = 2; m_cause = 1; end
                   else if (req_we && req_mode == 2'd1) m_st = 1;
                   else if (req_we && req_mode == 2'd2) begin m_st = 2; m_cause = 0; end
                1: if (m_pf) begin m_st = 2; m_cause = 1; end
                   else if (m_wake) m_st = 0;
                2: if (m_wake && !m_blk) begin m_st = 3; m_cnt = int'(settle_val); end
                default: if (m_cnt == 0) m_st = 0; else m_cnt--;
            endcase
            d2 = d1;
            d1 = {wake_irq, wake_key, bat_chg_n, pwr_fail_n, ext_pwr_n, bat_ok};
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // compare with the reference on every cycle
    always @(negedge clk) begin
        if (rst_n && armed) begin
            chk(phase, "cpu_clk_en", int'(cpu_clk_en), int'(m_st == 0));
            chk(phase, "periph_clk_en", int'(periph_clk_en), int'(m_st <= 1));
            chk(phase, "osc_en", int'(osc_en), int'(m_st != 2));
            chk(phase, "status", int'(status),
                int'({m_cause, (m_st == 3) ? 2'd2 : 2'(m_st)}));
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(logic [1:0] code);
        req_we = 1'b1; req_mode = code;
        step(1);
        req_we = 1'b0; req_mode = 2'd0;
    endtask

    task automatic pulse_key();
        wake_key = 1'b1; step(1); wake_key = 1'b0;
    endtask

    task automatic pulse_irq();
        wake_irq = 1'b1; step(1); wake_irq = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk("R1", "reset status", int'(status), 0);
        chk("R1", "reset enables", int'({cpu_clk_en, periph_clk_en, osc_en}), 7);

        // software requests
        phase = "R3";
        request(2'd0); step(2);
        chk("R3", "code 0 ignored", int'(status), 0);
        request(2'd3); step(2);
        chk("R3", "code 3 ignored", int'(status), 0);
        request(2'd1);
        chk("R3", "idle entered", int'(status), 1);
        chk("R2", "idle enables", int'({cpu_clk_en, periph_clk_en, osc_en}), 3);
        request(2'd2); step(1);
        chk("R3", "standby from idle ignored", int'(status), 1);

        // idle wake with sync latency
        phase = "R4";
        wake_key = 1'b1;
        step(2);
        chk("R10", "wake not yet acting", int'(status), 1);
        step(1);
        chk("R4", "idle to run", int'(status), 0);
        wake_key = 1'b0;

        // wakes in operating
        phase = "R9";
        pulse_irq(); pulse_key(); step(4);
        chk("R9", "wake in run ignored", int'(status), 0);

        // standby by software, settle of 5
        phase = "R5";
        settle_val = 16'd5;
        request(2'd2);
        chk("R3", "standby entered", int'(status), 2);
        chk("R2", "standby enables", int'({cpu_clk_en, periph_clk_en, osc_en}), 0);
        request(2'd1); step(1);
        chk("R3", "request in standby ignored", int'(status), 2);
        pulse_irq();
        step(2);
        chk("R5", "settling osc on", int'({cpu_clk_en, periph_clk_en, osc_en}), 1);
        pulse_key();
        step(4);
        chk("R5", "last settle cycle", int'(cpu_clk_en), 0);
        step(1);
        chk("R5", "run after settle", int'(status), 0);

        // settle of 0
        settle_val = 16'd0;
        request(2'd2); pulse_key(); step(2);
        chk("R5", "single settle cycle", int'(osc_en && !cpu_clk_en), 1);
        step(1);
        chk("R5", "run after zero settle", int'(cpu_clk_en), 1);

        // blocked wakes
        phase = "R6";
        settle_val = 16'd2;
        request(2'd2);
        bat_ok = 1'b0; ext_pwr_n = 1'b1; step(3);
        pulse_key(); step(5);
        chk("R6", "no supply blocks", int'(osc_en), 0);
        ext_pwr_n = 1'b0; step(3);
        pulse_key(); step(4);
        chk("R6", "external supply allows", int'(osc_en), 1);
        step(4);
        bat_ok = 1'b1; ext_pwr_n = 1'b1;
        request(2'd2);
        bat_chg_n = 1'b0; step(3);
        pulse_irq(); step(5);
        chk("R6", "battery change blocks", int'(osc_en), 0);
        bat_chg_n = 1'b1; step(3);
        pulse_irq(); step(8);
        chk("R6", "cleared fault wakes", int'(status), 0);

        // power fail with simultaneous request
        phase = "R7";
        pwr_fail_n = 1'b0; step(2);
        request(2'd1); step(1);
        chk("R7", "pfail standby", int'(status), 6);
        phase = "R6";
        pulse_key(); step(5);
        chk("R6", "pfail blocks wake", int'(osc_en), 0);
        pwr_fail_n = 1'b1; step(3);
        phase = "R8";
        pulse_key(); step(8);
        chk("R8", "cause kept in run", int'(status), 4);

        // power fail in idle, competing wake
        phase = "R7";
        request(2'd1);
        pwr_fail_n = 1'b0; wake_key = 1'b1; step(3);
        chk("R7", "pfail beats wake in idle", int'(status), 6);
        wake_key = 1'b0; pwr_fail_n = 1'b1; step(4);
        phase = "R8";
        pulse_irq(); step(8);
        request(2'd2);
        chk("R8", "software cause clears", int'(status), 2);
        pulse_key(); step(8);
        chk("R8", "cleared cause kept", int'(status), 0);

        summary();
        $finish;
    end
endmodule